// File: doc/BRIEF.md
# Pipeline Stall and Redirect Controller

This block holds the stall and redirect sequencing for a two-stage in-order pipeline, where a fetch stage feeds a combined decode/execute stage. Each cycle it is told whether decode/execute holds an instruction, and what kind. It also receives the branch condition result, a data-side response strobe, a completion strobe from the multiply/divide unit and a strobe from fetch that marks a valid instruction. From these it decides whether decode/execute must hold its instruction. It also decides when fetch and its prefetch buffer are discarded and when a new program counter is requested, and it names which target the new program counter comes from.

An instruction that stalls for X cycles keeps the stall output high for X cycles. It completes in the following cycle, where the stall output is low. The next instruction therefore enters decode/execute X+1 cycles after this one did. With no stalls the pipeline sustains one instruction per cycle. Stall, flush and PC request are combinational functions of the inputs and a small sequencer, so a redirect appears in the same cycle as the instruction that causes it. A parameter selects whether a dedicated adder computes branch targets. With the adder, a taken branch redirects in its first cycle. Without it, the shared ALU evaluates the condition first and computes the target one cycle later.

Top module: `pl_hazard_ctrl`

## Requirements
- R1: After reset, and with no instruction presented, stall_o, flush_o and pc_req_o are 0 and pc_sel_o is 2'b00.
- R2: Instruction classes are coded 0 arithmetic, 1 CSR, 2 load, 3 store, 4 jump, 5 branch, 6 multiply/divide, 7 instruction fence. An arithmetic op, a CSR op or a branch with branch_taken_i low completes in its first cycle: stall_o stays 0 and no redirect is issued.
- R3: A load or store raises stall_o in its first cycle even if mem_resp_i is high in that cycle. In later cycles stall_o stays high until the cycle in which mem_resp_i is high, and that cycle completes the instruction. The stall count is max(1, L) when the response is high from cycle L (counting the first cycle as 0) onward.
- R4: A multiply/divide holds stall_o high exactly while mdu_done_i is low, so it stalls L cycles when done is high from cycle L onward.
- R5: A jump raises pc_req_o and flush_o in its first cycle with pc_sel_o = 2'b01 (jump target), and stalls in that cycle.
- R6: After a redirect, stall_o stays high until the cycle in which fetch_valid_i is high. A fetch_valid_i seen in the redirect cycle itself is ignored.
- R7: With the target adder disabled, a taken branch stalls in its first cycle without a redirect. In its second cycle it raises pc_req_o and flush_o with pc_sel_o = 2'b10 (branch target) and stalls. From there it continues as in R6, for at least 2 stall cycles in total.
- R8: With the target adder enabled, a taken branch redirects in its first cycle with pc_sel_o = 2'b10 and stalls at least 1 cycle.
- R9: An instruction fence behaves exactly as a jump: same redirect cycle, select 2'b01 and stall count.
- R10: pc_req_o and flush_o are always equal and last one cycle per instruction. pc_sel_o is 2'b00 whenever no request is made.
- R11: While instr_valid_i is low and no instruction is held, stall_o and pc_req_o stay 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Decode/execute holds an instruction |
| instr_class_i | input | 3 | Class of that instruction (coding in R2) |
| branch_taken_i | input | 1 | Branch condition result |
| mem_resp_i | input | 1 | Data-side response arrived |
| mdu_done_i | input | 1 | Multiply/divide result ready |
| fetch_valid_i | input | 1 | Fetch offers a valid instruction |
| stall_o | output | 1 | Hold decode/execute |
| flush_o | output | 1 | Discard fetch stage and prefetch buffer |
| pc_req_o | output | 1 | Request a new program counter |
| pc_sel_o | output | 2 | PC source: 00 sequential, 01 jump, 10 branch |

## Verification
Every class is tried with and without the branch condition. The waited-for strobe is raised from delays 0 through 4, against both parameter settings. Delay 0 shows that a response or fetch strobe in the first or redirect cycle is ignored. Delays 1 and 2 separate the minimum stall from a strobe-driven stall. Longer delays show that the stall follows the strobe. Each instruction's stall count, redirect cycle, select value and flush/request agreement are compared against counts derived from the class, the delay and the parameter. Idle cycles with every strobe high, placed between instructions, show that nothing starts without a valid instruction.

// File: rtl/pl_hazard_pkg.sv
package pl_hazard_pkg;

    localparam int unsigned CLASS_W = 3;
    localparam int unsigned SEL_W   = 2;

    typedef enum logic [CLASS_W-1:0] {
        IC_ALU    = 3'd0,
        IC_CSR    = 3'd1,
        IC_LOAD   = 3'd2,
        IC_STORE  = 3'd3,
        IC_JUMP   = 3'd4,
        IC_BRANCH = 3'd5,
        IC_MULDIV = 3'd6,
        IC_FENCEI = 3'd7
    } iclass_e;

    typedef enum logic [SEL_W-1:0] {
        PCS_SEQ    = 2'd0,
        PCS_JUMP   = 2'd1,
        PCS_BRANCH = 2'd2
    } pcsel_e;

    typedef enum logic [1:0] {
        ST_FIRST      = 2'd0,
        ST_WAIT_MEM   = 2'd1,
        ST_BR_TARGET  = 2'd2,
        ST_WAIT_FETCH = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic plain;
        logic mem;
        logic jumpish;
        logic branch;
        logic muldiv;
    } class_flags_t;

    typedef struct packed {
        ctl_state_e state;
    } seq_state_t;

endpackage

// File: rtl/pl_hazard_classdec.sv
module pl_hazard_classdec
    import pl_hazard_pkg::*;
(
    input  logic                valid_i,
    input  logic [CLASS_W-1:0]  class_i,
    output class_flags_t        flags_o
);

    iclass_e cls;

    always_comb begin
        cls     = iclass_e'(class_i);
        flags_o = '0;
        if (valid_i) begin
            unique case (cls)
                IC_ALU, IC_CSR:      flags_o.plain   = 1'b1;
                IC_LOAD, IC_STORE:   flags_o.mem     = 1'b1;
                IC_JUMP, IC_FENCEI:  flags_o.jumpish = 1'b1;
                IC_BRANCH:           flags_o.branch  = 1'b1;
                IC_MULDIV:           flags_o.muldiv  = 1'b1;
                default:             flags_o         = '0;
            endcase
        end
    end

endmodule

// File: rtl/pl_hazard_seq.sv
module pl_hazard_seq
    import pl_hazard_pkg::*;
#(
    parameter bit BR_ADDER = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  class_flags_t  flags_i,
    input  logic          taken_i,
    input  logic          mem_resp_i,
    input  logic          mdu_done_i,
    input  logic          fetch_valid_i,
    output logic          stall_o,
    output logic          redirect_o,
    output pcsel_e        sel_o
);

    seq_state_t q, d;
    logic       early_target;

    // Parameter picks where a taken branch issues its redirect.
    generate
        if (BR_ADDER) begin : g_tgt_adder
            assign early_target = 1'b1;
        end else begin : g_shared_alu
            assign early_target = 1'b0;
        end
    endgenerate

    always_comb begin
        d          = q;
        stall_o    = 1'b0;
        redirect_o = 1'b0;
        sel_o      = PCS_SEQ;
        unique case (q.state)
            ST_FIRST: begin
                if (flags_i.mem) begin
                    // first cycle always waits, response ignored here
                    stall_o = 1'b1;
                    d.state = ST_WAIT_MEM;
                end else if (flags_i.muldiv) begin
                    stall_o = !mdu_done_i;
                end else if (flags_i.jumpish) begin
                    stall_o    = 1'b1;
                    redirect_o = 1'b1;
                    sel_o      = PCS_JUMP;
                    d.state    = ST_WAIT_FETCH;
                end else if (flags_i.branch && taken_i) begin
                    stall_o = 1'b1;
                    if (early_target) begin
                        redirect_o = 1'b1;
                        sel_o      = PCS_BRANCH;
                        d.state    = ST_WAIT_FETCH;
                    end else begin
                        d.state = ST_BR_TARGET;
                    end
                end
            end
            ST_WAIT_MEM: begin
                stall_o = !mem_resp_i;
                if (mem_resp_i) d.state = ST_FIRST;
            end
            ST_BR_TARGET: begin
                stall_o    = 1'b1;
                redirect_o = 1'b1;
                sel_o      = PCS_BRANCH;
                d.state    = ST_WAIT_FETCH;
            end
            ST_WAIT_FETCH: begin
                stall_o = !fetch_valid_i;
                if (fetch_valid_i) d.state = ST_FIRST;
            end
            default: d.state = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{state: ST_FIRST};
        else         q <= d;
    end

endmodule

// File: rtl/pl_hazard_ctrl.sv
module pl_hazard_ctrl
    import pl_hazard_pkg::*;
#(
    parameter bit BR_ADDER = 1'b0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                instr_valid_i,
    input  logic [CLASS_W-1:0]  instr_class_i,
    input  logic                branch_taken_i,
    input  logic                mem_resp_i,
    input  logic                mdu_done_i,
    input  logic                fetch_valid_i,
    output logic                stall_o,
    output logic                flush_o,
    output logic                pc_req_o,
    output logic [SEL_W-1:0]    pc_sel_o
);

    class_flags_t flags;
    logic         redirect;
    pcsel_e       sel;

    pl_hazard_classdec u_dec (
        .valid_i (instr_valid_i),
        .class_i (instr_class_i),
        .flags_o (flags)
    );

    pl_hazard_seq #(.BR_ADDER(BR_ADDER)) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .flags_i       (flags),
        .taken_i       (branch_taken_i),
        .mem_resp_i    (mem_resp_i),
        .mdu_done_i    (mdu_done_i),
        .fetch_valid_i (fetch_valid_i),
        .stall_o       (stall_o),
        .redirect_o    (redirect),
        .sel_o         (sel)
    );

    assign flush_o  = redirect;
    assign pc_req_o = redirect;
    assign pc_sel_o = sel;

endmodule

// File: rtl/pl_hazard_ctrl_chk.sv
module pl_hazard_ctrl_chk
    import pl_hazard_pkg::*;
#(
    parameter bit BR_ADDER = 1'b0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               instr_valid_i,
    input logic [CLASS_W-1:0] instr_class_i,
    input logic               branch_taken_i,
    input logic               mdu_done_i,
    input logic               stall_o,
    input logic               flush_o,
    input logic               pc_req_o,
    input logic [SEL_W-1:0]   pc_sel_o
);

    p_plain_nostall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !$past(stall_o) &&
         (instr_class_i == IC_ALU || instr_class_i == IC_CSR ||
          (instr_class_i == IC_BRANCH && !branch_taken_i)))
        |-> (!stall_o && !pc_req_o));

    p_mem_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !$past(stall_o) &&
         (instr_class_i == IC_LOAD || instr_class_i == IC_STORE))
        |-> stall_o);

    p_muldiv_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !$past(stall_o) && instr_class_i == IC_MULDIV)
        |-> (stall_o == !mdu_done_i));

    p_jump_redirect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !$past(stall_o) &&
         (instr_class_i == IC_JUMP || instr_class_i == IC_FENCEI))
        |-> (stall_o && pc_req_o && pc_sel_o == 2'b01));

    p_taken_branch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !$past(stall_o) && instr_class_i == IC_BRANCH &&
         branch_taken_i)
        |-> (stall_o && (pc_req_o == BR_ADDER)));

    p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_req_o |=> !pc_req_o);

    p_flush_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_o == pc_req_o) && (pc_req_o || pc_sel_o == 2'b00));

    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!instr_valid_i && !$past(stall_o)) |-> (!stall_o && !pc_req_o));

endmodule

bind pl_hazard_ctrl pl_hazard_ctrl_chk #(.BR_ADDER(BR_ADDER)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .instr_valid_i  (instr_valid_i),
    .instr_class_i  (instr_class_i),
    .branch_taken_i (branch_taken_i),
    .mdu_done_i     (mdu_done_i),
    .stall_o        (stall_o),
    .flush_o        (flush_o),
    .pc_req_o       (pc_req_o),
    .pc_sel_o       (pc_sel_o)
);

// File: tb/pl_hazard_ctrl_bench.sv
module pl_hazard_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid, taken, resp, done, fvalid;
    logic [2:0] cls;
    logic       s0, f0, r0, s1, f1, r1;
    logic [1:0] sel0, sel1;
    logic       obs;
    logic       o_stall, o_flush, o_req;
    logic [1:0] o_sel;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    pl_hazard_ctrl #(.BR_ADDER(1'b0)) u_pl_hazard_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_class_i(cls),
        .branch_taken_i(taken), .mem_resp_i(resp), .mdu_done_i(done),
        .fetch_valid_i(fvalid), .stall_o(s0), .flush_o(f0), .pc_req_o(r0),
        .pc_sel_o(sel0));

    pl_hazard_ctrl #(.BR_ADDER(1'b1)) u_pl_hazard_ctrl_tgt (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_class_i(cls),
        .branch_taken_i(taken), .mem_resp_i(resp), .mdu_done_i(done),
        .fetch_valid_i(fvalid), .stall_o(s1), .flush_o(f1), .pc_req_o(r1),
        .pc_sel_o(sel1));

    always_comb begin
        o_stall = obs ? s1 : s0;
        o_flush = obs ? f1 : f0;
        o_req   = obs ? r1 : r0;
        o_sel   = obs ? sel1 : sel0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        valid = 0; cls = 0; taken = 0; resp = 0; done = 0; fvalid = 0;
    endtask

    // idle cycle with every strobe high (R11)
    task automatic idle_check();
        @(negedge clk);
        valid = 0; cls = 3'd4; taken = 1; resp = 1; done = 1; fvalid = 1;
        #3;
        chk(!o_stall && !o_req, "R11", "idle stall/req", {o_stall, o_req}, 0);
    endtask

    task automatic run_instr(input int c, input bit tk, input int lat);
        int    stalls = 0, reqs = 0, req_at = -1, bad = 0;
        int    exp_stalls, exp_reqs, exp_at, exp_sel;
        bit    fin = 0;
        string tag;
        exp_reqs = 0; exp_at = -1; exp_sel = 0;
        case (c)
            0, 1: begin exp_stalls = 0; tag = "R2"; end
            2, 3: begin exp_stalls = (lat > 1) ? lat : 1; tag = "R3"; end
            6:    begin exp_stalls = lat; tag = "R4"; end
            4, 7: begin
                exp_stalls = (lat > 1) ? lat : 1; exp_reqs = 1; exp_at = 0;
                exp_sel = 1; tag = (c == 4) ? "R5/R6" : "R9/R6";
            end
            default: begin
                if (!tk) begin exp_stalls = 0; tag = "R2"; end
                else if (obs) begin
                    exp_stalls = (lat > 1) ? lat : 1; exp_reqs = 1; exp_at = 0;
                    exp_sel = 2; tag = "R8/R6";
                end else begin
                    exp_stalls = (lat > 2) ? lat : 2; exp_reqs = 1; exp_at = 1;
                    exp_sel = 2; tag = "R7/R6";
                end
            end
        endcase
        for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
            @(negedge clk);
            valid = 1; cls = 3'(c); taken = tk;
            resp = (cyc >= lat); done = (cyc >= lat); fvalid = (cyc >= lat);
            #3;
            if (o_req) begin
                reqs++; req_at = cyc;
                if (o_sel != 2'(exp_sel)) bad++;
            end else if (o_sel != 2'b00) bad++;
            if (o_flush != o_req) bad++;
            if (o_stall) stalls++; else fin = 1;
        end
        chk(stalls == exp_stalls, tag, $sformatf("stall count cls%0d tk%0d lat%0d", c, tk, lat),
            stalls, exp_stalls);
        chk(reqs == exp_reqs && req_at == exp_at, tag,
            $sformatf("redirect cycle cls%0d tk%0d lat%0d", c, tk, lat), req_at, exp_at);
        chk(bad == 0, "R10", $sformatf("sel/flush cls%0d tk%0d lat%0d", c, tk, lat), bad, 0);
    endtask

    initial begin
        obs = 0;
        quiet_inputs();
        for (int p = 0; p < 2; p++) begin
            obs = p[0];
            rst_n = 0;
            repeat (3) @(posedge clk);
            @(negedge clk);
            rst_n = 1;
            #3;
            chk(!o_stall && !o_flush && !o_req && o_sel == 2'b00, "R1", "reset outputs",
                {o_stall, o_flush, o_req, o_sel}, 0);
            for (int c = 0; c < 8; c++)
                for (int tk = 0; tk < 2; tk++)
                    for (int lat = 0; lat < 5; lat++) begin
                        run_instr(c, tk[0], lat);
                        if (lat == 2) idle_check();
                    end
            @(negedge clk);
            quiet_inputs();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule